// File: doc/BRIEF.md
# Debounced Qualified Event Counters

This block holds a small bank of read-only event counters for a battery-backed memory slave. Two counters follow active-low trigger inputs, A and B, each filtered by its own debounce stage. The B counter counts every filtered low-going pulse on B. The A counter counts a filtered low-going pulse on A only when a complete low pulse on B has ended since the last A count. When A and B come from two sensors on a rotating part, this keeps a short reverse swing from being counted. The remaining counters count commit strobes to the memory page each one belongs to.

A read port returns the count that belongs to a requested page at once, with no clock delay. A page with no counter reads as all ones. The power-on clear, an asynchronous active-low reset, sets every counter to zero. Nothing on the bus side can write a counter. In the default build the counters are 32 bits wide. Pages 12 and 13 hold write-cycle counters, page 14 holds the A counter and page 15 holds the B counter. The debounce time is set in clock cycles.

Top module: `evc_top`

## Requirements
- R1: While `rst_n` is low, every counter is zero, so a read of any counter page returns 0.
- R2: The B counter rises by exactly one for each filtered low pulse on `trig_b_n`. The count is taken when the filtered level falls.
- R3: A filtered falling edge on `trig_a_n` is counted only if a filtered rising edge of B has occurred since the last A count. A second A pulse with no new complete B pulse between them is not counted.
- R4: An A pulse that starts and ends while B is still low is not counted. B has fallen but not yet risen, so no complete B pulse has been seen.
- R5: A `wr_stb` with `wr_page` equal to 12 or 13 raises that page's counter by one. A strobe to any other page leaves every counter unchanged.
- R6: A read of a page with no counter (0 to 11 by default) returns all ones on `rd_count`.
- R7: A low or high excursion on a trigger input lasting fewer than DEBOUNCE_CYCLES clocks does not change the filtered level and counts nothing.
- R8: Counters wrap from all ones to zero.
- R9: `rd_count` follows `rd_page` in the same cycle. In a cycle where the read page's counter is incremented, it shows the value from before the increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on clear |
| trig_a_n | input | 1 | Raw active-low trigger A |
| trig_b_n | input | 1 | Raw active-low trigger B |
| wr_stb | input | 1 | Page commit strobe, one cycle per commit |
| wr_page | input | PAGE_W (4) | Page index of the commit |
| rd_page | input | PAGE_W (4) | Page index to read |
| rd_count | output | COUNT_W (32) | Count for `rd_page`, or all ones |

## Verification
The bench builds the block with DEBOUNCE_CYCLES of 4 and COUNT_W of 8. With the short debounce, each pulse or glitch costs only a few dozen clocks, so hundreds of random A, B, glitch and commit events fit in one run. With 8-bit counters, the wrap from all ones to zero is reached after 256 commits. The page map keeps its default, so the read decode is tested exactly as it is built.

// File: rtl/evc_pkg.sv
package evc_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_A    = 2'd1,
    SRC_B    = 2'd2,
    SRC_WC   = 2'd3
  } evc_src_e;
endpackage

// File: rtl/evc_debounce.sv
module evc_debounce #(
  parameter int DEBOUNCE_CYCLES = 36250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_n,
  output logic filt_n,
  output logic fall,
  output logic rise
);
  localparam int CW = (DEBOUNCE_CYCLES < 2) ? 1 : $clog2(DEBOUNCE_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(DEBOUNCE_CYCLES - 1);

  logic          sync1_q, sync2_q, filt_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          filt_d, flip;

  // the filtered level flips after DEBOUNCE_CYCLES differing samples in a row
  assign flip = (sync2_q != filt_q) && (cnt_q == LAST);

  always_comb begin
    cnt_d  = cnt_q;
    filt_d = filt_q;
    if (sync2_q == filt_q) begin
      cnt_d = '0;
    end else if (flip) begin
      cnt_d  = '0;
      filt_d = sync2_q;
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b1;
      sync2_q <= 1'b1;
      filt_q  <= 1'b1;
      cnt_q   <= '0;
    end else begin
      sync1_q <= raw_n;
      sync2_q <= sync1_q;
      filt_q  <= filt_d;
      cnt_q   <= cnt_d;
    end
  end

  assign filt_n = filt_q;
  assign fall   = flip &  filt_q;
  assign rise   = flip & ~filt_q;
endmodule

// File: rtl/evc_qual.sv
module evc_qual (
  input  logic clk,
  input  logic rst_n,
  input  logic a_fall,
  input  logic b_rise,
  output logic a_count,
  output logic armed
);
  logic arm_q, arm_d;

  assign a_count = a_fall & arm_q;

  always_comb begin
    arm_d = arm_q | b_rise;
    if (a_count) arm_d = b_rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) arm_q <= 1'b0;
    else        arm_q <= arm_d;
  end

  assign armed = arm_q;
endmodule

// File: rtl/evc_counter.sv
module evc_counter #(
  parameter int COUNT_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               inc,
  output logic [COUNT_W-1:0] value
);
  logic [COUNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (inc) cnt_d = cnt_q + COUNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign value = cnt_q;
endmodule

// File: rtl/evc_top.sv
module evc_top #(
  parameter int COUNT_W         = 32,
  parameter int PAGE_W          = 4,
  parameter int DEBOUNCE_CYCLES = 36250,
  parameter int NUM_WC          = 2,
  parameter int WC_BASE         = 12,
  parameter int A_PAGE          = 14,
  parameter int B_PAGE          = 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trig_a_n,
  input  logic               trig_b_n,
  input  logic               wr_stb,
  input  logic [PAGE_W-1:0]  wr_page,
  input  logic [PAGE_W-1:0]  rd_page,
  output logic [COUNT_W-1:0] rd_count
);
  import evc_pkg::*;

  localparam int IDX_W = (NUM_WC > 1) ? $clog2(NUM_WC) : 1;

  logic a_filt, a_fall, a_rise;
  logic b_filt, b_fall, b_rise;
  logic a_count, armed;
  logic [COUNT_W-1:0] cnt_a, cnt_b;
  logic [NUM_WC-1:0][COUNT_W-1:0] wc_cnt;

  evc_debounce #(.DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)) deb_a_i (
    .clk(clk), .rst_n(rst_n), .raw_n(trig_a_n),
    .filt_n(a_filt), .fall(a_fall), .rise(a_rise));

  evc_debounce #(.DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)) deb_b_i (
    .clk(clk), .rst_n(rst_n), .raw_n(trig_b_n),
    .filt_n(b_filt), .fall(b_fall), .rise(b_rise));

  evc_qual qual_i (
    .clk(clk), .rst_n(rst_n), .a_fall(a_fall), .b_rise(b_rise),
    .a_count(a_count), .armed(armed));

  evc_counter #(.COUNT_W(COUNT_W)) cnt_a_i (
    .clk(clk), .rst_n(rst_n), .inc(a_count), .value(cnt_a));

  evc_counter #(.COUNT_W(COUNT_W)) cnt_b_i (
    .clk(clk), .rst_n(rst_n), .inc(b_fall), .value(cnt_b));

  for (genvar g = 0; g < NUM_WC; g++) begin : g_wc
    logic hit;
    assign hit = wr_stb && (wr_page == PAGE_W'(WC_BASE + g));
    evc_counter #(.COUNT_W(COUNT_W)) cnt_wc_i (
      .clk(clk), .rst_n(rst_n), .inc(hit), .value(wc_cnt[g]));
  end

  // read decode
  evc_src_e         src;
  logic [IDX_W-1:0] wc_idx;

  always_comb begin
    src    = SRC_NONE;
    wc_idx = '0;
    if (rd_page == PAGE_W'(A_PAGE)) begin
      src = SRC_A;
    end else if (rd_page == PAGE_W'(B_PAGE)) begin
      src = SRC_B;
    end else begin
      for (int i = 0; i < NUM_WC; i++) begin
        if (rd_page == PAGE_W'(WC_BASE + i)) begin
          src    = SRC_WC;
          wc_idx = IDX_W'(i);
        end
      end
    end
  end

  always_comb begin
    unique case (src)
      SRC_A:   rd_count = cnt_a;
      SRC_B:   rd_count = cnt_b;
      SRC_WC:  rd_count = wc_cnt[wc_idx];
      default: rd_count = '1;
    endcase
  end
endmodule

// File: rtl/evc_chk.sv
module evc_chk #(
  parameter int COUNT_W = 32,
  parameter int PAGE_W  = 4,
  parameter int NUM_WC  = 2,
  parameter int WC_BASE = 12,
  parameter int A_PAGE  = 14,
  parameter int B_PAGE  = 15
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           wr_stb,
  input logic [PAGE_W-1:0]              wr_page,
  input logic [PAGE_W-1:0]              rd_page,
  input logic [COUNT_W-1:0]             rd_count,
  input logic [COUNT_W-1:0]             cnt_a,
  input logic [COUNT_W-1:0]             cnt_b,
  input logic [NUM_WC-1:0][COUNT_W-1:0] wc_cnt,
  input logic                           armed
);
  function automatic logic is_wc(input logic [PAGE_W-1:0] p);
    logic r;
    r = 1'b0;
    for (int i = 0; i < NUM_WC; i++)
      if (p == PAGE_W'(WC_BASE + i)) r = 1'b1;
    return r;
  endfunction

  logic rd_has_cnt;
  assign rd_has_cnt = is_wc(rd_page) || (rd_page == PAGE_W'(A_PAGE)) ||
                      (rd_page == PAGE_W'(B_PAGE));

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_CLEAR_ON_RESET: assert (cnt_a == '0 && cnt_b == '0 && wc_cnt == '0); // R1
    end
  end

  AST_B_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_b != $past(cnt_b)) |-> (cnt_b == $past(cnt_b) + COUNT_W'(1))); // R2

  AST_A_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_a != $past(cnt_a)) |-> $past(armed)); // R3

  AST_WC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !is_wc(wr_page)) |=> $stable(wc_cnt)); // R5

  AST_ABSENT_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_has_cnt |-> (rd_count == '1)); // R6
endmodule

bind evc_top evc_chk #(
  .COUNT_W(COUNT_W), .PAGE_W(PAGE_W), .NUM_WC(NUM_WC),
  .WC_BASE(WC_BASE), .A_PAGE(A_PAGE), .B_PAGE(B_PAGE)
) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_page(wr_page),
  .rd_page(rd_page), .rd_count(rd_count), .cnt_a(cnt_a), .cnt_b(cnt_b),
  .wc_cnt(wc_cnt), .armed(armed)
);

// File: tb/evc_top_tb_top.sv
module evc_top_tb_top;
  localparam int CW  = 8;
  localparam int PW  = 4;
  localparam int DEB = 4;
  localparam int HOLD = DEB + 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig_a_n = 1'b1, trig_b_n = 1'b1, wr_stb = 1'b0;
  logic [PW-1:0] wr_page = '0, rd_page = '0;
  logic [CW-1:0] rd_count;

  always #4 clk = ~clk;

  evc_top #(.COUNT_W(CW), .PAGE_W(PW), .DEBOUNCE_CYCLES(DEB)) dut_i (
    .clk(clk), .rst_n(rst_n), .trig_a_n(trig_a_n), .trig_b_n(trig_b_n),
    .wr_stb(wr_stb), .wr_page(wr_page), .rd_page(rd_page), .rd_count(rd_count));

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [CW-1:0] exp_a = '0, exp_b = '0;
  logic [CW-1:0] exp_wc [2] = '{default: '0};
  bit armed_m = 0;

  function automatic logic [CW-1:0] model_read(input logic [PW-1:0] p);
    if (p == 4'd14) return exp_a;
    if (p == 4'd15) return exp_b;
    if (p == 4'd12) return exp_wc[0];
    if (p == 4'd13) return exp_wc[1];
    return '1;
  endfunction

  task automatic check(input string tag, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic read_chk(input string tag, input logic [PW-1:0] p);
    @(negedge clk);
    rd_page = p;
    #1;
    check(tag, rd_count, model_read(p));
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_b();
    @(negedge clk); trig_b_n = 1'b0; wait_cyc(HOLD);
    trig_b_n = 1'b1; wait_cyc(HOLD);
    exp_b++; armed_m = 1;
  endtask

  task automatic pulse_a();
    @(negedge clk); trig_a_n = 1'b0; wait_cyc(HOLD);
    trig_a_n = 1'b1; wait_cyc(HOLD);
    if (armed_m) begin exp_a++; armed_m = 0; end
  endtask

  task automatic glitch(input bit on_a, input bit high_glitch);
    int len;
    len = 1 + int'($urandom_range(0, DEB - 3));
    @(negedge clk);
    if (on_a) trig_a_n = high_glitch; else trig_b_n = high_glitch;
    wait_cyc(len);
    if (on_a) trig_a_n = ~high_glitch; else trig_b_n = ~high_glitch;
    wait_cyc(HOLD);
  endtask

  task automatic commit(input logic [PW-1:0] p);
    @(negedge clk); wr_stb = 1'b1; wr_page = p;
    @(negedge clk); wr_stb = 1'b0;
    if (p == 4'd12) exp_wc[0]++;
    if (p == 4'd13) exp_wc[1]++;
  endtask

  task automatic check_all(input string tag);
    read_chk({tag, " A"}, 4'd14);
    read_chk({tag, " B"}, 4'd15);
    read_chk({tag, " W12"}, 4'd12);
    read_chk({tag, " W13"}, 4'd13);
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    wait_cyc(3);
    // R1: counters zero in reset
    read_chk("R1 reset A", 4'd14);
    read_chk("R1 reset W12", 4'd12);
    rst_n = 1'b1;
    wait_cyc(2);
    check_all("R1 after release");

    // R2: B pulses
    pulse_b(); pulse_b();
    read_chk("R2 B two pulses", 4'd15);

    // R3: first A counts (armed), second does not
    pulse_a();
    read_chk("R3 A after B", 4'd14);
    pulse_a();
    read_chk("R3 A repeat without B", 4'd14);

    // R4: A pulse inside an open B low pulse
    @(negedge clk); trig_b_n = 1'b0; wait_cyc(HOLD);
    pulse_a();
    read_chk("R4 A during B low", 4'd14);
    trig_b_n = 1'b1; wait_cyc(HOLD);
    exp_b++; armed_m = 1;
    pulse_a();
    read_chk("R4 A after B completes", 4'd14);
    read_chk("R2 B after nested", 4'd15);

    // R7: short glitches on both inputs, both polarities
    glitch(0, 0); glitch(1, 0);
    check_all("R7 low glitch");
    @(negedge clk); trig_b_n = 1'b0; wait_cyc(HOLD);
    glitch(0, 1);
    trig_b_n = 1'b1; wait_cyc(HOLD);
    exp_b++; armed_m = 1;
    read_chk("R7 high glitch inside B low", 4'd15);

    // R5: commits to counter pages and others
    commit(4'd12); commit(4'd13); commit(4'd13);
    commit(4'd3); commit(4'd14); commit(4'd15);
    check_all("R5 commits");

    // R6: pages without counters
    for (int p = 0; p < 12; p++) read_chk("R6 absent page", PW'(p));

    // R9: same-cycle read and increment
    @(negedge clk); wr_stb = 1'b1; wr_page = 4'd12; rd_page = 4'd12;
    #1; check("R9 pre-increment value", rd_count, exp_wc[0]);
    @(negedge clk); wr_stb = 1'b0; exp_wc[0]++;
    #1; check("R9 post-increment value", rd_count, exp_wc[0]);

    // R8: wrap of the page 13 counter
    while (exp_wc[1] != 8'hFF) commit(4'd13);
    read_chk("R8 at all ones", 4'd13);
    commit(4'd13);
    read_chk("R8 wrapped to zero", 4'd13);

    // random mix
    for (int it = 0; it < 300; it++) begin
      int op;
      op = int'($urandom_range(0, 5));
      case (op)
        0: pulse_a();
        1: pulse_b();
        2: glitch($urandom_range(0, 1) == 1, 1'b0);
        default: commit(PW'($urandom_range(0, 15)));
      endcase
      if (it % 25 == 24) check_all("R2 R3 R5 R7 random");
    end
    check_all("R2 R3 R5 random final");

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule